// File: doc/BRIEF.md
# Multi-Hit Interval Counting Time Digitizer Channel

This block is one channel of a counter-based time digitizer. A qualified fast-clock tick advances an interval counter. Each accepted hit does three things in one cycle: it captures the running count as a time word, restarts the counter and appends the word to a small multi-hit buffer. So each word holds the time between two successive hits, not an absolute timestamp. The channel only acts inside a measurement window. A common start pulse opens the window, clears the counter and clears the sticky loss flag. A common stop pulse closes the window.

Buffered words drain through a parallel-to-serial port. A slow readout tick paces the port, and this tick is independent of the counting tick. The oldest word goes out first. Each frame begins with a marker bit that is not part of the value. Next come the count bits, MSB first, and last comes a saturation flag. A second mode swaps the inputs so the channel measures charge or area. In that mode a pulse input drives the counter, and a sampling input drives capture, so each word counts the pulses in one sampling period. All inputs are synchronous qualifiers, sampled on the rising edge of `clk`.

Top module: `tdc_channel`

## Requirements
- R1: While the window is open, each cycle with a count event and `clkEnable` high adds one to the counter. A captured word equals the number of such cycles since the previous capture or since common start. For example, 2000 and 4000 ticks read back as 2000 and 4000.
- R2: A count event in a cycle with `clkEnable` low is not counted.
- R3: An accepted capture restarts the counter. If a count event falls in the same cycle as the capture, it belongs to the next interval, so the next word starts from 1.
- R4: The buffer holds `DEPTH` words. A capture while the buffer is full is dropped and sets `ovfFlag`. Fullness is judged on the occupancy before the cycle, even when a readout pop happens in the same cycle. `ovfFlag` stays set until a common start, and a common start clears it.
- R5: A capture event with `inhibit` high is ignored, and the counter keeps running through it.
- R6: `startIn` opens the window and zeroes the counter. Capture and count events in the start cycle, and any before the first start, are ignored. After `stopIn`, the channel ignores count and capture events.
- R7: The counter saturates at all ones. A word captured at all ones has its saturation flag set to 1. Otherwise the flag is 0.
- R8: A serial frame is `CNT_W+2` bits, one bit per `rdTick` while `rdReq` is high. The bits go out in this order: marker bit 1, then count bits MSB to LSB, then the saturation flag. Words leave oldest first, and each word leaves the buffer when its frame starts.
- R9: When no frame is being sent, `serValid` and `serOut` are both 0. This includes a request made while the buffer is empty. The serial outputs change only in cycles with `rdTick`.
- R10: With `chargeMode` high, `pulseIn` is the count event and `sampleIn` is the capture event. `cntTick` and `hitIn` have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | Fast-clock tick, the count event in interval mode |
| hitIn | input | 1 | Hit, the capture event in interval mode |
| pulseIn | input | 1 | Input pulse, the count event in charge mode |
| sampleIn | input | 1 | Sampling strobe, the capture event in charge mode |
| chargeMode | input | 1 | 1 selects the pulse-counting role swap |
| startIn | input | 1 | Common start: opens window, clears counter and loss flag |
| stopIn | input | 1 | Common stop: closes window |
| clkEnable | input | 1 | Gates count events into the counter |
| inhibit | input | 1 | Blocks capture without stopping the counter |
| rdTick | input | 1 | Readout pacing tick, one serial bit per tick |
| rdReq | input | 1 | Readout request |
| serOut | output | 1 | Serial data |
| serValid | output | 1 | High while a frame bit is on serOut |
| ovfFlag | output | 1 | Sticky buffer-loss flag |

## Verification
Two collisions matter here, and each is forced by driving both events on the same cycle. The first is a count tick landing on the same cycle as a hit. The bench judges it by whether the next word starts at 1 rather than 0. The second is a hit arriving while the buffer is full on the cycle the serializer pops the oldest word. The bench then expects the hit to be lost and `ovfFlag` to rise, and it expects exactly the three earlier words to drain in order. Random traffic with enable gaps, inhibits and overflows is compared against a bench model of the counter and buffer.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  // Strobes issued by the control to the datapath, one cycle each.
  typedef struct packed {
    logic cntEvent;    // qualified count event this cycle
    logic cntRestart;  // capture accepted: restart interval
    logic cntClear;    // common start: zero the counter
    logic push;        // write captured word into buffer
    logic setOvf;      // capture lost because buffer full
    logic clrOvf;      // clear sticky loss flag
    logic serLoad;     // pop oldest word into the serializer
    logic serShift;    // advance serializer by one bit
    logic serStop;     // end of frame, go idle
  } tdc_strobe_t;

  // State fed back from the datapath to the control.
  typedef struct packed {
    logic full;
    logic empty;
    logic serBusy;
    logic serLast;
  } tdc_status_t;

endpackage

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
  import tdc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntTick,
  input  logic        hitIn,
  input  logic        pulseIn,
  input  logic        sampleIn,
  input  logic        chargeMode,
  input  logic        startIn,
  input  logic        stopIn,
  input  logic        clkEnable,
  input  logic        inhibit,
  input  logic        rdTick,
  input  logic        rdReq,
  input  tdc_status_t status,
  output tdc_strobe_t strobe
);

  logic armed;
  logic countSrc;
  logic captureSrc;
  logic captureOk;
  logic countOk;
  logic frameEnding;

  // Measurement window: start wins over stop in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)        armed <= 1'b0;
    else if (startIn) armed <= 1'b1;
    else if (stopIn)  armed <= 1'b0;
  end

  // Role swap between interval mode and pulse-counting mode.
  always_comb begin
    if (chargeMode) begin
      countSrc   = pulseIn;
      captureSrc = sampleIn;
    end else begin
      countSrc   = cntTick;
      captureSrc = hitIn;
    end
  end

  assign countOk     = armed && !startIn && clkEnable && countSrc;
  assign captureOk   = armed && !startIn && captureSrc && !inhibit;
  assign frameEnding = status.serBusy && status.serLast;

  always_comb begin
    strobe            = '0;
    strobe.cntEvent   = countOk;
    strobe.cntRestart = captureOk;
    strobe.cntClear   = startIn;
    strobe.push       = captureOk && !status.full;
    strobe.setOvf     = captureOk && status.full;
    strobe.clrOvf     = startIn;
    strobe.serLoad    = rdTick && rdReq && !status.empty
                        && (!status.serBusy || status.serLast);
    strobe.serShift   = rdTick && status.serBusy && !status.serLast;
    strobe.serStop    = rdTick && frameEnding && !strobe.serLoad;
  end

endmodule

// File: rtl/tdc_datapath.sv
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  tdc_strobe_t strobe,
  output tdc_status_t status,
  output logic        serOut,
  output logic        serValid,
  output logic        ovfFlag
);

  localparam int WORD_W  = CNT_W + 1;
  localparam int FRAME_W = CNT_W + 2;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W   = $clog2(DEPTH + 1);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL  = LVL_W'(DEPTH);
  localparam logic [BIT_W-1:0] BITS_INIT = BIT_W'(FRAME_W - 1);

  // ---------------- interval counter ----------------
  logic [CNT_W-1:0]  intervalCnt;
  logic [WORD_W-1:0] capWord;

  always_ff @(posedge clk) begin
    if (!rstN)                  intervalCnt <= '0;
    else if (strobe.cntClear)   intervalCnt <= '0;
    else if (strobe.cntRestart) intervalCnt <= CNT_W'(strobe.cntEvent);
    else if (strobe.cntEvent && intervalCnt != CNT_MAX)
      intervalCnt <= intervalCnt + 1'b1;
  end

  assign capWord = {intervalCnt == CNT_MAX, intervalCnt};

  // ---------------- multi-hit buffer ----------------
  logic [WORD_W-1:0] slotData [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  level;
  logic              popWord;

  assign popWord = strobe.serLoad;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strobe.push && wrPtr == PTR_W'(g)) slotData[g] <= capWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobe.push) wrPtr <= stepPtr(wrPtr);
      if (popWord)     rdPtr <= stepPtr(rdPtr);
      unique case ({strobe.push, popWord})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // ---------------- sticky loss flag ----------------
  always_ff @(posedge clk) begin
    if (!rstN)              ovfFlag <= 1'b0;
    else if (strobe.clrOvf) ovfFlag <= 1'b0;
    else if (strobe.setOvf) ovfFlag <= 1'b1;
  end

  // ---------------- parallel-to-serial ----------------
  logic [FRAME_W-1:0] shReg;
  logic [BIT_W-1:0]   bitsLeft;
  logic               busy;
  logic [WORD_W-1:0]  headWord;

  assign headWord = slotData[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      bitsLeft <= '0;
      busy     <= 1'b0;
    end else if (strobe.serLoad) begin
      shReg    <= {1'b1, headWord[CNT_W-1:0], headWord[CNT_W]};
      bitsLeft <= BITS_INIT;
      busy     <= 1'b1;
    end else if (strobe.serShift) begin
      shReg    <= {shReg[FRAME_W-2:0], 1'b0};
      bitsLeft <= bitsLeft - 1'b1;
    end else if (strobe.serStop) begin
      busy     <= 1'b0;
    end
  end

  assign serOut   = busy & shReg[FRAME_W-1];
  assign serValid = busy;

  always_comb begin
    status.full    = (level == LVL_FULL);
    status.empty   = (level == '0);
    status.serBusy = busy;
    status.serLast = (bitsLeft == '0);
  end

endmodule

// File: rtl/tdc_channel.sv
module tdc_channel
  import tdc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic cntTick,
  input  logic hitIn,
  input  logic pulseIn,
  input  logic sampleIn,
  input  logic chargeMode,
  input  logic startIn,
  input  logic stopIn,
  input  logic clkEnable,
  input  logic inhibit,
  input  logic rdTick,
  input  logic rdReq,
  output logic serOut,
  output logic serValid,
  output logic ovfFlag
);

  tdc_strobe_t strobe;
  tdc_status_t status;

  tdc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cntTick   (cntTick),
    .hitIn     (hitIn),
    .pulseIn   (pulseIn),
    .sampleIn  (sampleIn),
    .chargeMode(chargeMode),
    .startIn   (startIn),
    .stopIn    (stopIn),
    .clkEnable (clkEnable),
    .inhibit   (inhibit),
    .rdTick    (rdTick),
    .rdReq     (rdReq),
    .status    (status),
    .strobe    (strobe)
  );

  tdc_datapath #(
    .CNT_W(CNT_W),
    .DEPTH(DEPTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .status  (status),
    .serOut  (serOut),
    .serValid(serValid),
    .ovfFlag (ovfFlag)
  );

endmodule

// File: rtl/tdc_channel_chk.sv
module tdc_channel_chk (
  input logic clk,
  input logic rstN,
  input logic hitIn,
  input logic sampleIn,
  input logic chargeMode,
  input logic startIn,
  input logic inhibit,
  input logic rdTick,
  input logic rdReq,
  input logic serOut,
  input logic serValid,
  input logic ovfFlag
);

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !serValid |-> !serOut);

  p_paced_by_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdTick |=> ($stable(serValid) && $stable(serOut)));

  p_marker_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serValid) |-> serOut);

  p_frame_on_request_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serValid) |-> $past(rdReq && rdTick));

  p_start_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> !ovfFlag);

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !startIn) |=> ovfFlag);

  p_ovf_needs_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(chargeMode ? sampleIn : hitIn) && !$past(inhibit)));

endmodule

bind tdc_channel tdc_channel_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hitIn     (hitIn),
  .sampleIn  (sampleIn),
  .chargeMode(chargeMode),
  .startIn   (startIn),
  .inhibit   (inhibit),
  .rdTick    (rdTick),
  .rdReq     (rdReq),
  .serOut    (serOut),
  .serValid  (serValid),
  .ovfFlag   (ovfFlag)
);

// File: tb/tdc_channel_bench.sv
module tdc_channel_bench;

  localparam int CNT_W   = 12;
  localparam int DEPTH   = 3;
  localparam int FRAME_W = CNT_W + 2;
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntTick = 0, hitIn = 0, pulseIn = 0, sampleIn = 0, chargeMode = 0;
  logic startIn = 0, stopIn = 0, clkEnable = 0, inhibit = 0, rdTick = 0, rdReq = 0;
  logic serOut, serValid, ovfFlag;

  always #10 clk = ~clk;

  tdc_channel #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_tdc_channel (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .hitIn(hitIn),
    .pulseIn(pulseIn), .sampleIn(sampleIn), .chargeMode(chargeMode),
    .startIn(startIn), .stopIn(stopIn), .clkEnable(clkEnable),
    .inhibit(inhibit), .rdTick(rdTick), .rdReq(rdReq),
    .serOut(serOut), .serValid(serValid), .ovfFlag(ovfFlag)
  );

  int  nChk = 0;
  int  nBad = 0;
  bit  finished = 0;
  int  mCnt = 0;
  bit  mOvf = 0;
  bit  mArmed = 0;
  int  q[$];

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mkWord(int c);
    return ((c == CMAX) ? (1 << CNT_W) : 0) | c;
  endfunction

  function automatic int frameOf(int w);
    return (1 << (CNT_W + 1)) | ((w & CMAX) << 1) | ((w >> CNT_W) & 1);
  endfunction

  function automatic void modelStep(bit cnt, bit cap);
    if (cap) begin
      if (q.size() < DEPTH) q.push_back(mkWord(mCnt));
      else mOvf = 1;
      mCnt = cnt ? 1 : 0;
    end else if (cnt && mCnt < CMAX) begin
      mCnt++;
    end
  endfunction

  task automatic clearStim();
    startIn = 0; stopIn = 0; rdTick = 0; inhibit = 0; clkEnable = 0;
    cntTick = 0; hitIn = 0; pulseIn = 0; sampleIn = 0;
  endtask

  task automatic cyc(bit tk, bit en, bit ht, bit inh);
    @(negedge clk);
    clearStim();
    clkEnable = en; inhibit = inh;
    if (chargeMode) begin
      pulseIn = tk; sampleIn = ht; cntTick = 1; hitIn = 1;  // R10 decoys
    end else begin
      cntTick = tk; hitIn = ht;
    end
    if (mArmed) modelStep(tk && en, ht && !inh);
  endtask

  task automatic ticks(int n, bit en);
    repeat (n) cyc(1, en, 0, 0);
  endtask

  task automatic hit();
    cyc(0, 1, 1, 0);
  endtask

  task automatic doStart();
    @(negedge clk);
    clearStim();
    startIn = 1;
    mArmed = 1; mCnt = 0; mOvf = 0;
  endtask

  task automatic doStop();
    @(negedge clk);
    clearStim();
    stopIn = 1;
    mArmed = 0;
  endtask

  // Read one frame; optionally fire a hit in the same cycle as the load.
  task automatic readWord(string req, bit hitFirst);
    int exp, got, w;
    bit allValid;
    got = 0; allValid = 1;
    for (int i = 0; i < FRAME_W; i++) begin
      @(negedge clk);
      clearStim();
      rdReq = 1; rdTick = 1;
      if (i == 0 && hitFirst) begin
        hitIn = 1;
        if (mArmed) modelStep(0, 1);
      end
      @(negedge clk);
      clearStim();
      got = (got << 1) | int'(serOut);
      allValid &= serValid;
    end
    w = (q.size() > 0) ? q.pop_front() : 0;
    exp = frameOf(w);
    chk({req, " frame"}, got, exp);
    chk({req, " valid during frame"}, int'(allValid), 1);
    @(negedge clk);
    rdReq = 0; rdTick = 1;
    @(negedge clk);
    rdTick = 0;
    chk("R9 valid low after frame", int'(serValid), 0);
  endtask

  task automatic readEmpty(string req);
    @(negedge clk);
    clearStim();
    rdReq = 1; rdTick = 1;
    @(negedge clk);
    rdReq = 0; rdTick = 0;
    chk({req, " empty valid"}, int'(serValid), 0);
    chk({req, " empty data"}, int'(serOut), 0);
  endtask

  task automatic drain(string req);
    while (q.size() > 0) readWord(req, 0);
    readEmpty(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R9 reset valid", int'(serValid), 0);
    chk("R9 reset data", int'(serOut), 0);
    chk("R4 reset ovf", int'(ovfFlag), 0);

    // R6: nothing is captured before the first start
    ticks(5, 1); hit(); hit();
    readEmpty("R6 pre-start");

    // R1, R2, R8: plain intervals with an enable gap
    doStart();
    ticks(5, 1); hit();
    ticks(3, 0); ticks(2, 1); hit();
    drain("R1 R2 R8");

    // R3: count tick in the same cycle as the hit
    doStart();
    ticks(4, 1); cyc(1, 1, 1, 0); ticks(2, 1); hit();
    drain("R3");

    // R5: inhibited hit, counter keeps running
    doStart();
    ticks(3, 1); cyc(0, 1, 1, 1); ticks(3, 1); hit();
    chk("R5 one word", q.size(), 1);
    drain("R5");

    // R1: long intervals 2000 and 4000
    doStart();
    ticks(2000, 1); hit(); ticks(4000, 1); hit();
    drain("R1 long");

    // R6: start-cycle events ignored, stop closes window
    doStart();
    ticks(2, 1); hit(); doStop();
    ticks(4, 1); hit(); hit();
    drain("R6 stop");

    // R4: overflow drops a hit, start clears the flag
    doStart();
    for (int k = 1; k <= DEPTH + 1; k++) begin ticks(k, 1); hit(); end
    @(negedge clk); clearStim();
    chk("R4 ovf set", int'(ovfFlag), int'(mOvf));
    drain("R4");
    chk("R4 ovf held", int'(ovfFlag), 1);
    doStart();
    @(negedge clk); clearStim();
    chk("R4 ovf cleared", int'(ovfFlag), 0);

    // R4 collision: full buffer, hit on the pop cycle is lost
    for (int k = 1; k <= DEPTH; k++) begin ticks(k, 1); hit(); end
    readWord("R4 collision", 1);
    chk("R4 collision ovf", int'(ovfFlag), 1);
    drain("R4 collision");

    // R7: saturation
    doStart();
    ticks(CMAX + 5, 1); hit();
    ticks(7, 1); hit();
    drain("R7");

    // R10: charge mode, cntTick and hitIn held high as decoys
    chargeMode = 1;
    doStart();
    ticks(7, 1); hit(); ticks(2, 0); ticks(3, 1); hit();
    drain("R10");
    chargeMode = 0;

    // Random traffic against the model
    doStart();
    for (int i = 0; i < 600; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 5) != 0,
          ($urandom % 20) == 0, ($urandom % 6) == 0);
      if (i % 150 == 149) begin
        @(negedge clk); clearStim();
        chk("R4 random ovf", int'(ovfFlag), int'(mOvf));
        drain("R1 R3 R5 random");
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule